// File: doc/BRIEF.md
# Return Stack and Program-Flow Unit

This unit sits beside the instruction decoder of a dual-stack processor. Every cycle it computes the next program counter and maintains the return stack. Its inputs are a small transfer opcode, a branch target, the current program counter, the data-stack top T and the carry flag. The unit decides whether a branch is taken and what address goes out as the next program counter. In the same cycle it pushes, pops or adjusts the return stack.

The top of the return stack sits in a register of its own, R, which the rest of the core can read directly. The deeper levels live in a circular store below it. Together R and the store hold `DEPTH` entries.

Besides call and return, the unit handles several more operations. These are unconditional branches, branches conditional on a zero T or a set carry, moves of T onto the return stack and of R back out, and a counted-loop operation that counts R down and falls out of the loop when R is zero.

Top module: `rstk_branch_unit`

## Requirements
- R1: `op_code` encodings are NOP=0, BRA=1, BZ=2, BC=3, CALL=4, RET=5, NEXT=6, PUSHR=7, POPR=8. Any other code acts as NOP. On NOP, `pc_next` = `pc_cur`+1 (modulo 2^AW) and `r_top` does not change.
- R2: On BRA, `pc_next` equals `target`.
- R3: On BZ, `pc_next` is `target` when `tos` is zero and otherwise `pc_cur`+1. On BC, `pc_next` is `target` when `carry` is 1 and otherwise `pc_cur`+1.
- R4: On CALL, `pc_next` equals `target`. The value `pc_cur`+1, zero-extended to DW bits, is pushed and appears on `r_top` after the clock edge.
- R5: On RET, `pc_next` equals the low AW bits of `r_top` in the same cycle, and the return stack is popped.
- R6: On NEXT with `r_top` non-zero, `pc_next` is `target` and `r_top` decrements by one. On NEXT with `r_top` zero, `pc_next` is `pc_cur`+1 and the return stack is popped. A loop entered with count n therefore branches back n times.
- R7: On PUSHR, `tos` is pushed onto the return stack. On POPR, the value to move into T is the `r_top` of that cycle, and the return stack is popped.
- R8: The return stack holds DEPTH entries (default 32) of DW bits in last-in, first-out order. A push onto a full stack discards the oldest entry, so the most recent DEPTH values remain retrievable.
- R9: A synchronous active-high `rst` clears `r_top` to zero and empties the stack.
- R10: `pc_next` is combinational: it reflects the inputs of the current cycle with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Transfer opcode (encodings in R1) |
| target | input | AW | Branch or call destination |
| pc_cur | input | AW | Program counter of the current instruction |
| tos | input | DW | Data-stack top T |
| carry | input | 1 | Carry flag |
| pc_next | output | AW | Next program counter |
| r_top | output | DW | Top of the return stack, R |

## Verification
The bound checker checks the following properties on every cycle:
- the branch target on BRA;
- the sequential address on NOP;
- `r_top` is unchanged on NOP;
- the return address taken from R on RET;
- the pushed return address after CALL;
- the pushed T after PUSHR;
- the single-step decrement on a taken NEXT.

Only the bench scenarios can show the properties that depend on history: last-in, first-out order across a full-depth nest of calls, loss of only the oldest entry on overflow, the exact number of loop iterations followed by the pop that exposes the entry underneath, and the taken/not-taken sweep of the conditional branches.

// File: rtl/rsbu_pkg.sv
package rsbu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_BRA   = 4'd1,
        OP_BZ    = 4'd2,
        OP_BC    = 4'd3,
        OP_CALL  = 4'd4,
        OP_RET   = 4'd5,
        OP_NEXT  = 4'd6,
        OP_PUSHR = 4'd7,
        OP_POPR  = 4'd8
    } xfer_op_e;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_DEC
    } stk_act_e;

    typedef struct packed {
        xfer_op_e op;
        logic     carry;
    } flow_ctl_t;

endpackage

// File: rtl/rsbu_flow.sv
module rsbu_flow
    import rsbu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  flow_ctl_t         ctl,
    input  logic [AW-1:0]     target,
    input  logic [AW-1:0]     pc_cur,
    input  logic [DW-1:0]     tos,
    input  logic [DW-1:0]     r_top,
    output logic [AW-1:0]     pc_next,
    output stk_act_e          act,
    output logic [DW-1:0]     push_val
);

    logic [AW-1:0] pc_seq;
    logic          r_zero;
    logic          t_zero;

    assign pc_seq = pc_cur + AW'(1);
    assign r_zero = (r_top == '0);
    assign t_zero = (tos == '0);

    always_comb begin
        pc_next  = pc_seq;
        act      = STK_HOLD;
        push_val = tos;
        unique case (ctl.op)
            OP_BRA: pc_next = target;
            OP_BZ:  if (t_zero)    pc_next = target;
            OP_BC:  if (ctl.carry) pc_next = target;
            OP_CALL: begin
                pc_next            = target;
                act                = STK_PUSH;
                push_val           = '0;
                push_val[AW-1:0]   = pc_seq;
            end
            OP_RET: begin
                pc_next = r_top[AW-1:0];
                act     = STK_POP;
            end
            OP_NEXT: begin
                if (!r_zero) begin
                    pc_next = target;
                    act     = STK_DEC;
                end else begin
                    act     = STK_POP;
                end
            end
            OP_PUSHR: act = STK_PUSH;
            OP_POPR:  act = STK_POP;
            default:  ;
        endcase
    end

endmodule

// File: rtl/rsbu_stack.sv
module rsbu_stack
    import rsbu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_act_e      act,
    input  logic [DW-1:0] push_val,
    output logic [DW-1:0] r_top
);

    localparam int BELOW = DEPTH - 1;
    localparam int PW    = (BELOW > 1) ? $clog2(BELOW) : 1;

    logic [DW-1:0] below_q [BELOW];
    logic [DW-1:0] r_q;
    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_inc;
    logic [PW-1:0] sp_dec;

    assign sp_inc = (sp_q == PW'(BELOW - 1)) ? '0 : sp_q + 1'b1;
    assign sp_dec = (sp_q == '0) ? PW'(BELOW - 1) : sp_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q  <= '0;
            sp_q <= '0;
        end else begin
            unique case (act)
                STK_PUSH: begin
                    r_q  <= push_val;
                    sp_q <= sp_inc;
                end
                STK_POP: begin
                    r_q  <= below_q[sp_dec];
                    sp_q <= sp_dec;
                end
                STK_DEC:  r_q <= r_q - DW'(1);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && act == STK_PUSH) begin
            below_q[sp_q] <= r_q;
        end
    end

    assign r_top = r_q;

endmodule

// File: rtl/rstk_branch_unit.sv
module rstk_branch_unit
    import rsbu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_code,
    input  logic [AW-1:0]   target,
    input  logic [AW-1:0]   pc_cur,
    input  logic [DW-1:0]   tos,
    input  logic            carry,
    output logic [AW-1:0]   pc_next,
    output logic [DW-1:0]   r_top
);

    flow_ctl_t     ctl;
    stk_act_e      act;
    logic [DW-1:0] push_val;

    always_comb begin
        ctl.carry = carry;
        if (op_code <= OP_W'(OP_POPR)) ctl.op = xfer_op_e'(op_code);
        else                           ctl.op = OP_NOP;
    end

    rsbu_flow #(.AW(AW), .DW(DW)) u_flow (
        .ctl      (ctl),
        .target   (target),
        .pc_cur   (pc_cur),
        .tos      (tos),
        .r_top    (r_top),
        .pc_next  (pc_next),
        .act      (act),
        .push_val (push_val)
    );

    rsbu_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .push_val (push_val),
        .r_top    (r_top)
    );

endmodule

// File: rtl/rstk_branch_unit_chk.sv
module rstk_branch_unit_chk
    import rsbu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] op_code,
    input logic [AW-1:0]   target,
    input logic [AW-1:0]   pc_cur,
    input logic [DW-1:0]   tos,
    input logic            carry,
    input logic [AW-1:0]   pc_next,
    input logic [DW-1:0]   r_top
);

    logic [DW-1:0] ret_ext;
    always_comb begin
        ret_ext         = '0;
        ret_ext[AW-1:0] = pc_cur + AW'(1);
    end

    // R2
    p_bra_target_r2: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_BRA |-> pc_next == target);

    // R1
    p_nop_seq_r1: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_NOP |-> pc_next == pc_cur + AW'(1));

    // R1
    p_nop_hold_r1: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_NOP |=> $stable(r_top));

    // R4
    p_call_push_r4: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_CALL |=> r_top == $past(ret_ext));

    // R5
    p_ret_from_r_r5: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_RET |-> pc_next == r_top[AW-1:0]);

    // R6
    p_next_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_NEXT && r_top != '0) |=> r_top == $past(r_top) - DW'(1));

    // R7
    p_pushr_r7: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_PUSHR |=> r_top == $past(tos));

endmodule

bind rstk_branch_unit rstk_branch_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/rstk_branch_unit_tb.sv
`timescale 1ns/1ps
module rstk_branch_unit_tb;
    import rsbu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] target = '0;
    logic [31:0] pc_cur = '0;
    logic [31:0] tos = '0;
    logic        carry = 1'b0;
    logic [31:0] pc_next;
    logic [31:0] r_top;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rstk_branch_unit u_dut (
        .clk(clk), .rst(rst), .op_code(op_code), .target(target),
        .pc_cur(pc_cur), .tos(tos), .carry(carry),
        .pc_next(pc_next), .r_top(r_top)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst     = 1'b1;
        op_code = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one instruction, check pc_next combinationally, advance past the edge
    task automatic apply(input logic [3:0] o, input logic [31:0] tg, input logic [31:0] pc,
                         input logic [31:0] t, input logic c, input logic [31:0] exp_pc,
                         input string tag);
        op_code = o; target = tg; pc_cur = pc; tos = t; carry = c;
        #1;
        chk(pc_next, exp_pc, tag);
        @(negedge clk);
        op_code = 4'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk(r_top, 32'h0, "R9 reset clears r_top");

        // R1 NOP sweep including wrap, plus undefined codes
        for (int i = 0; i < 8; i++) begin
            logic [31:0] p;
            p = 32'hFFFF_FFFC + 32'(i);
            apply(4'd0, 32'h1234, p, 32'h9, 1'b1, p + 32'd1, "R1 NOP advance");
        end
        for (int code = 9; code < 16; code++)
            apply(4'(code), 32'h1234, 32'h40, 32'h0, 1'b1, 32'h41, "R1 undefined code acts as NOP");
        chk(r_top, 32'h0, "R1 NOP leaves r_top");

        // R2 BRA
        for (int i = 0; i < 6; i++)
            apply(OP_BRA, 32'h100 * 32'(i) + 32'h3, 32'h77, 32'(i), 1'(i), 32'h100 * 32'(i) + 32'h3, "R2 BRA");

        // R3 conditional branches, R10 same-cycle pc_next
        for (int t = 0; t < 3; t++)
            for (int c = 0; c < 2; c++) begin
                apply(OP_BZ, 32'hA00, 32'h50, 32'(t), 1'(c),
                      (t == 0) ? 32'hA00 : 32'h51, "R3 BZ");
                apply(OP_BC, 32'hB00, 32'h60, 32'(t), 1'(c),
                      (c == 1) ? 32'hB00 : 32'h61, "R3 BC R10");
            end

        // R4 R5 R8 full-depth call nest then unwind
        do_reset();
        for (int i = 0; i < 32; i++) begin
            apply(OP_CALL, 32'h1000 + 32'(i), 32'(i) * 32'd16, 32'h0, 1'b0,
                  32'h1000 + 32'(i), "R4 CALL target");
            chk(r_top, 32'(i) * 32'd16 + 32'd1, "R4 CALL return address");
        end
        for (int k = 0; k < 32; k++)
            apply(OP_RET, 32'h0, 32'h9999, 32'h0, 1'b0,
                  32'(31 - k) * 32'd16 + 32'd1, "R5 R8 RET order");

        // R8 overflow: 33 pushes keep the latest 32
        do_reset();
        for (int i = 0; i < 33; i++)
            apply(OP_PUSHR, 32'h0, 32'h10, 32'd100 + 32'(i), 1'b0, 32'h11, "R7 PUSHR");
        chk(r_top, 32'd132, "R7 PUSHR top value");
        for (int k = 0; k < 31; k++)
            apply(OP_POPR, 32'h0, 32'h20, 32'h0, 1'b0, 32'h21, "R7 POPR");
        chk(r_top, 32'd101, "R8 overflow drops only oldest");

        // R6 counted loop with an entry underneath
        do_reset();
        apply(OP_PUSHR, 32'h0, 32'h1FE, 32'h55, 1'b0, 32'h1FF, "R6 setup");
        apply(OP_PUSHR, 32'h0, 32'h1FF, 32'h3, 1'b0, 32'h200, "R6 setup");
        for (int k = 0; k < 3; k++) begin
            apply(OP_NEXT, 32'h1F0, 32'h200, 32'h0, 1'b0, 32'h1F0, "R6 NEXT taken");
            chk(r_top, 32'(2 - k), "R6 NEXT decrement");
        end
        apply(OP_NEXT, 32'h1F0, 32'h200, 32'h0, 1'b0, 32'h201, "R6 NEXT fall through");
        chk(r_top, 32'h55, "R6 NEXT pops at zero");

        // R7 POPR exposes value then pops
        apply(OP_PUSHR, 32'h0, 32'h300, 32'hDEAD_BEEF, 1'b0, 32'h301, "R7 PUSHR");
        chk(r_top, 32'hDEAD_BEEF, "R7 value visible for POPR");
        apply(OP_POPR, 32'h0, 32'h301, 32'h0, 1'b0, 32'h302, "R7 POPR");
        chk(r_top, 32'h55, "R7 POPR pops");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule